// File: doc/BRIEF.md
# DDS Control-Word Loader

This block is the control-word front end of a direct digital synthesizer. It builds a 40-bit word that carries a 32-bit frequency tuning value and an 8-bit control byte, and it keeps that word away from the synthesis core until software asks for it to be used. The word arrives either a byte at a time on an 8-bit port or one bit at a time on the top line of that port. Each rising edge of a write strobe takes in one byte or one bit.

A separate update strobe copies the assembled word into the active registers in one step, so the core never sees a half-written word. The same edge returns the byte pointer to the first slot. A synchronous active-low reset clears the active registers and the pointer. After reset the output frequency is zero and the phase is at the cosine-0 point. The input register is not cleared, so a word loaded before reset can still be committed after it.

Both strobes are ordinary signals in the system clock domain. The block detects their rising edges. The loading mode is taken from a select input while reset is held.

Top module: `dds_word_loader`

## Requirements
- R1: While `rst_n` is low, the active frequency, phase offset, power-down flag, change pulse and byte pointer all clear to zero (phase zero is the cosine-0 point). The assembled input word is left as it was, so an update strobe after reset commits the word loaded before reset.
- R2: In parallel mode the byte pointer sets where each write goes. Slot 0 takes the control byte. Slots 1 to 4 take the frequency word, most significant byte first (slot 1 is bits 31:24 and slot 4 is bits 7:0).
- R3: In the control byte, bits 7:3 are the 5-bit phase offset and bit 2 is the power-down flag. Bits 1:0 have no effect on any output.
- R4: Only a rising edge of `wr_stb_i` or `upd_stb_i` acts. A strobe held high for several cycles counts as one event.
- R5: A rising edge of `upd_stb_i` copies the assembled word to the active outputs, which show it from the clock edge that sees the strobe rise. The same edge sets the byte pointer to slot 0.
- R6: In parallel mode, write strobes after the fifth one since the last update or reset are ignored and leave the assembled word unchanged.
- R7: In serial mode each write edge shifts in `data_i[7]`, least significant bit first. Of the last 40 bits shifted in, the first 32 form the frequency word (bit 0 first) and the last 8 form the control byte (bit 0 first). Earlier bits are shifted out and lost.
- R8: `serial_sel_i` is sampled while `rst_n` is low (1 = serial, 0 = parallel). A change on it after reset is released has no effect until the next reset.
- R9: `word_chg_o` is high for exactly one cycle after an update edge that changes the active frequency, phase offset or power-down flag. It stays low after an update that commits identical values.
- R10: Without an update edge, the active outputs hold their values whatever is written to the input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| serial_sel_i | input | 1 | Loading mode select, sampled during reset (1 = serial) |
| wr_stb_i | input | 1 | Write strobe; each rising edge loads a byte or a bit |
| upd_stb_i | input | 1 | Update strobe; each rising edge commits the word and rewinds the pointer |
| data_i | input | 8 | Byte input; bit 7 is also the serial data line |
| freq_word_o | output | 32 | Active frequency tuning word |
| phase_ofs_o | output | 5 | Active phase offset |
| pwr_down_o | output | 1 | Active power-down flag |
| word_chg_o | output | 1 | One-cycle pulse when the active word changes |

## Verification
All of the block's state sits behind the update strobe. A wrong pointer, a byte stored in the wrong slot or a wrong shift direction stays hidden until the next update. Then it shows on the frequency or phase outputs as a misplaced byte or a bit-reversed value in the very next cycle. A wrong mode capture or a lost input register after reset shows the same way, at the first commit after reset. A broken edge detector or change-pulse compare shows at once as a pulse that is missing or lasts more than one cycle on `word_chg_o`, or as a shifted word.

// File: rtl/dds_ldr_pkg.sv
// Package: shared types for the DDS control-word loader.
// Assumes an 8-bit control byte with a 5-bit phase field on top.
package dds_ldr_pkg;

    localparam int PHASE_W = 5;

    // Control byte layout, most significant field first.
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pwr_down;
        logic [1:0]         spare;
    } ctrl_byte_t;

    typedef enum logic {
        MODE_PARALLEL = 1'b0,
        MODE_SERIAL   = 1'b1
    } load_mode_e;

endpackage

// File: rtl/dds_edge_det.sv
// Rising-edge detector for a strobe already in the clk domain.
// The history register follows the input even during reset, so a
// strobe held high across reset release does not count as an edge.
module dds_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic prev_q;

    // Record last cycle's level.
    always_ff @(posedge clk) begin
        prev_q <= level_i;
    end

    // One-cycle pulse on a low-to-high transition, quiet in reset.
    always_comb begin
        rise_o = rst_n & level_i & ~prev_q;
    end

    // R4: an edge can never last two cycles.
    p_single_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dds_word_assembler.sv
// Input register, byte pointer and loading mode of the loader.
// Parallel mode writes byte slots selected by the pointer; serial mode
// shifts data bit BUS_W-1 in LSB first. The input register has no reset.
module dds_word_assembler
    import dds_ldr_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int BUS_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               serial_sel_i,
    input  logic               wr_edge_i,
    input  logic               upd_edge_i,
    input  logic [BUS_W-1:0]   data_i,
    output logic [FREQ_W-1:0]  freq_o,
    output ctrl_byte_t         ctrl_o
);

    localparam int WORD_W    = FREQ_W + BUS_W;
    localparam int NUM_SLOTS = WORD_W / BUS_W;
    localparam int PTR_W     = $clog2(NUM_SLOTS + 1);
    localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(NUM_SLOTS);

    load_mode_e         mode_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [WORD_W-1:0]  word_q;
    logic               par_wr;

    // A parallel write lands only while a free slot remains.
    always_comb begin
        par_wr = wr_edge_i && (mode_q == MODE_PARALLEL) && (ptr_q != PTR_FULL);
    end

    // Capture the loading mode while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= serial_sel_i ? MODE_SERIAL : MODE_PARALLEL;
        end
    end

    // Byte pointer: cleared by reset and by update, saturates at the end.
    always_ff @(posedge clk) begin
        if (!rst_n || upd_edge_i) begin
            ptr_q <= '0;
        end else if (par_wr) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // Input register: slot write or serial shift, kept across reset.
    always_ff @(posedge clk) begin
        if (rst_n && wr_edge_i) begin
            if (mode_q == MODE_SERIAL) begin
                word_q <= {data_i[BUS_W-1], word_q[WORD_W-1:1]};
            end else begin
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (par_wr && ptr_q == PTR_W'(s)) begin
                        word_q[(NUM_SLOTS-s)*BUS_W-1 -: BUS_W] <= data_i;
                    end
                end
            end
        end
    end

    // Split the staged word into its frequency and control parts.
    always_comb begin
        freq_o = word_q[FREQ_W-1:0];
        ctrl_o = ctrl_byte_t'(word_q[WORD_W-1:FREQ_W]);
    end

    // R5: an update edge rewinds the pointer.
    p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_edge_i |=> (ptr_q == '0));

    // R6: pointer never passes the last slot.
    p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_FULL);

    // R6: a full pointer in parallel mode freezes the staged word.
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PARALLEL && ptr_q == PTR_FULL) |=> $stable(word_q));

    // R8: mode does not move outside reset.
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

    // R1: pointer is zero right after a reset cycle.
    p_ptr_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (ptr_q == '0));

endmodule

// File: rtl/dds_active_regs.sv
// Active frequency, phase and power-down registers plus change pulse.
// Loads the staged values on a commit; reset gives frequency zero at
// the cosine-0 phase point.
module dds_active_regs
    import dds_ldr_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit_i,
    input  logic [FREQ_W-1:0]   freq_i,
    input  logic [PHASE_W-1:0]  phase_i,
    input  logic                pwr_down_i,
    output logic [FREQ_W-1:0]   freq_o,
    output logic [PHASE_W-1:0]  phase_o,
    output logic                pwr_down_o,
    output logic                chg_o
);

    logic differs;

    // Does the staged word change anything that is visible?
    always_comb begin
        differs = {freq_i, phase_i, pwr_down_i} != {freq_o, phase_o, pwr_down_o};
    end

    // Commit the staged word and flag a visible change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_o     <= '0;
            phase_o    <= '0;
            pwr_down_o <= 1'b0;
            chg_o      <= 1'b0;
        end else begin
            chg_o <= commit_i && differs;
            if (commit_i) begin
                freq_o     <= freq_i;
                phase_o    <= phase_i;
                pwr_down_o <= pwr_down_i;
            end
        end
    end

    // R1: reset leaves every active output at zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (freq_o == '0 && phase_o == '0 && !pwr_down_o && !chg_o));

    // R10: outputs hold when no commit happens.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> ($stable(freq_o) && $stable(phase_o) && $stable(pwr_down_o)));

    // R9: the change pulse lasts a single cycle.
    p_chg_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> !chg_o);

    // R9: the change pulse only follows a commit.
    p_chg_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_o) |-> $past(commit_i));

endmodule

// File: rtl/dds_word_loader.sv
// Top of the DDS control-word loader: edge detection on both strobes,
// word assembly in the selected mode, and the active register bank.
// Assumes all inputs are synchronous to clk.
module dds_word_loader
    import dds_ldr_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int BUS_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               serial_sel_i,
    input  logic               wr_stb_i,
    input  logic               upd_stb_i,
    input  logic [BUS_W-1:0]   data_i,
    output logic [FREQ_W-1:0]  freq_word_o,
    output logic [PHASE_W-1:0] phase_ofs_o,
    output logic               pwr_down_o,
    output logic               word_chg_o
);

    logic              wr_edge;
    logic              upd_edge;
    logic [FREQ_W-1:0] stage_freq;
    ctrl_byte_t        stage_ctrl;

    dds_edge_det u_wr_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (wr_stb_i),
        .rise_o  (wr_edge)
    );

    dds_edge_det u_upd_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (upd_stb_i),
        .rise_o  (upd_edge)
    );

    dds_word_assembler #(
        .FREQ_W (FREQ_W),
        .BUS_W  (BUS_W)
    ) u_asm (
        .clk          (clk),
        .rst_n        (rst_n),
        .serial_sel_i (serial_sel_i),
        .wr_edge_i    (wr_edge),
        .upd_edge_i   (upd_edge),
        .data_i       (data_i),
        .freq_o       (stage_freq),
        .ctrl_o       (stage_ctrl)
    );

    dds_active_regs #(
        .FREQ_W (FREQ_W)
    ) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (upd_edge),
        .freq_i     (stage_freq),
        .phase_i    (stage_ctrl.phase),
        .pwr_down_i (stage_ctrl.pwr_down),
        .freq_o     (freq_word_o),
        .phase_o    (phase_ofs_o),
        .pwr_down_o (pwr_down_o),
        .chg_o      (word_chg_o)
    );

    // R5: an update edge makes the outputs equal the staged word.
    p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_edge |=> (freq_word_o == $past(stage_freq)
                      && phase_ofs_o == $past(stage_ctrl.phase)));

endmodule

// File: tb/dds_word_loader_test.sv
module dds_word_loader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        serial_sel = 1'b0;
    logic        wr_stb = 1'b0;
    logic        upd_stb = 1'b0;
    logic [7:0]  data = 8'h00;
    logic [31:0] freq;
    logic [4:0]  phase;
    logic        pd;
    logic        chg;

    int n_chk = 0;
    int n_bad = 0;
    logic [39:0] act_word = '0;   // bench model of the committed word

    always #10 clk = ~clk;

    dds_word_loader uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .serial_sel_i (serial_sel),
        .wr_stb_i     (wr_stb),
        .upd_stb_i    (upd_stb),
        .data_i       (data),
        .freq_word_o  (freq),
        .phase_ofs_o  (phase),
        .pwr_down_o   (pd),
        .word_chg_o   (chg)
    );

    // Word layout used in the bench: {control byte, frequency}.
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        40'hF8_12345678, 40'h04_FFFFFFFF, 40'h5B_80000001,
        40'h00_00000000, 40'h00_00000000, 40'hA7_00C0FFEE
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_hold(input logic [7:0] b, input int cyc);
        @(negedge clk);
        data = b;
        wr_stb = 1'b1;
        repeat (cyc) @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wr_word(input logic [39:0] w);
        wr_hold(w[39:32], 1);
        for (int k = 3; k >= 0; k--) wr_hold(w[k*8 +: 8], 1);
    endtask

    task automatic ser_bit(input logic b);
        wr_hold({b, 7'h2A}, 1);
    endtask

    // Update edge; checks outputs and the change pulse one edge later.
    task automatic update_check(input string req, input logic [39:0] exp_w);
        logic exp_chg;
        exp_chg = (exp_w[31:0] != act_word[31:0]) || (exp_w[39:34] != act_word[39:34]);
        @(negedge clk);
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        check({req, " freq"}, 64'(freq), 64'(exp_w[31:0]));
        check({req, " phase R3"}, 64'(phase), 64'(exp_w[39:35]));
        check({req, " pwrdown R3"}, 64'(pd), 64'(exp_w[34]));
        check("R9 change pulse", 64'(chg), 64'(exp_chg));
        @(negedge clk);
        check("R9 pulse ends", 64'(chg), 64'(0));
        act_word = exp_w;
    endtask

    task automatic do_reset(input logic sel);
        @(negedge clk);
        rst_n = 1'b0;
        serial_sel = sel;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        act_word = '0;
    endtask

    initial begin
        #(20 * 200000);
        $display("FAIL watchdog: got timeout expected completion");
        n_bad++;
        n_chk++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        @(negedge clk);
        // R1 reset state
        check("R1 freq", 64'(freq), 64'(0));
        check("R1 phase", 64'(phase), 64'(0));
        check("R1 pwrdown", 64'(pd), 64'(0));
        check("R1 chg", 64'(chg), 64'(0));

        // R2, R3, R5, R9: table walk in parallel mode
        for (int i = 0; i < NV; i++) begin
            wr_word(VEC[i]);
            update_check("R2 R5 table", VEC[i]);
        end

        // R4: first byte strobe held three cycles; R10: no commit yet
        wr_hold(8'h61, 3);
        wr_hold(8'hDE, 1);
        wr_hold(8'hAD, 2);
        wr_hold(8'hBE, 1);
        wr_hold(8'hEF, 1);
        @(negedge clk);
        check("R10 hold freq", 64'(freq), 64'(act_word[31:0]));
        check("R10 hold chg", 64'(chg), 64'(0));
        update_check("R4 held strobe", 40'h61_DEADBEEF);

        // R6: writes beyond the fifth are ignored
        wr_word(40'h33_13579BDF);
        wr_hold(8'hFF, 1);
        wr_hold(8'h00, 1);
        update_check("R6 overflow", 40'h33_13579BDF);

        // R1: input word survives reset
        wr_word(40'hC4_2468ACE0);
        do_reset(1'b0);
        @(negedge clk);
        check("R1 freq after reset", 64'(freq), 64'(0));
        update_check("R1 retained word", 40'hC4_2468ACE0);

        // R1: reset rewinds a half-used pointer
        wr_hold(8'h11, 1);
        wr_hold(8'h22, 1);
        wr_hold(8'h33, 1);
        do_reset(1'b0);
        wr_word(40'h88_01020304);
        update_check("R1 pointer rewind", 40'h88_01020304);

        // R7, R8: serial mode, select dropped after reset
        do_reset(1'b1);
        @(negedge clk);
        serial_sel = 1'b0;
        ser_bit(1'b1);
        ser_bit(1'b1);
        for (int b = 0; b < 40; b++) ser_bit(VEC[5][b] ^ 1'b0 ? 1'b1 : 1'b0);
        update_check("R7 R8 serial", VEC[5]);
        for (int b = 0; b < 40; b++) ser_bit(40'h9A_0F1E2D3C >> b);
        update_check("R7 serial second", 40'h9A_0F1E2D3C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule